// File: doc/BRIEF.md
# Processor Mode and Size Decoder

This block condenses a processor's architectural control state into one registered summary word. The word tells a decoder which operating mode is in force and which widths apply. The inputs are:

- the long-mode-active bit;
- the protection-enable and paging bits of the main control register;
- the virtual-8086 flag;
- the code segment's long bit, default-size bit and privilege level;
- the stack segment's default-size bit.

From these the block derives:

- the mode and its submode;
- the current privilege level;
- a default and an alternate operand size, where the alternate is the one an override prefix selects;
- a default and an alternate address size;
- the stack width.

The summary is recomputed only when the recompute strobe is raised. Between strobes the word holds, so consumers see a stable view while the control state is being edited. Every size field is a 2-bit log2-of-bytes code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit.

Top module: `cpu_mode_decoder`

## Requirements
- R1: When long_act_i is 1, the mode field is 1 (long). The submode is 4 (64-bit) if cs_long_i is 1, and 3 (compatibility) otherwise.
- R2: When long_act_i is 0, the mode field is 0 (legacy). The submode is 0 (real) if prot_en_i is 0, 1 (virtual-8086) if prot_en_i and v86_i are both 1, and 2 (protected) otherwise.
- R3: In submode 4, or when cs_dsize_i is 1, the default operand code is 2 and the alternate is 1. Otherwise the default is 1 and the alternate is 2.
- R4: The address codes depend on the submode and cs_dsize_i:
  - in submode 4, the default is 3 and the alternate is 2;
  - otherwise, when cs_dsize_i is 1, the default is 2 and the alternate is 1;
  - otherwise the default is 1 and the alternate is 2.
- R5: The stack code is 3 in submode 4. Otherwise it is 2 when ss_dsize_i is 1, and 1 when it is 0.
- R6: The privilege field copies cs_dpl_i. The paging bit copies paging_i and the protection bit copies prot_en_i.
- R7: The summary word takes new values on the clock edge that samples recalc_i high. On edges where recalc_i is low it keeps its previous value, whatever the inputs do.
- R8: A synchronous active-low reset loads the real-mode summary, and reset takes priority over recalc_i. The real-mode summary is mode 0, submode 0, privilege 0, paging 0, protection 0, operand default 1 with alternate 2, address default 1 with alternate 2, and stack 1.
- R9: The fields of summary_o sit at fixed bit positions:

  | Bits | Field |
  |------|-------|
  | [0] | mode |
  | [3:1] | submode |
  | [5:4] | privilege |
  | [6] | paging |
  | [7] | protection |
  | [9:8] | default operand |
  | [11:10] | alternate operand |
  | [13:12] | default address |
  | [15:14] | alternate address |
  | [17:16] | stack |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recalc_i | input | 1 | Recompute strobe |
| long_act_i | input | 1 | Long mode active |
| prot_en_i | input | 1 | Protection enable from the main control register |
| paging_i | input | 1 | Paging enable from the main control register |
| v86_i | input | 1 | Virtual-8086 flag |
| cs_long_i | input | 1 | Code segment long bit |
| cs_dsize_i | input | 1 | Code segment default-size bit |
| ss_dsize_i | input | 1 | Stack segment default-size bit |
| cs_dpl_i | input | 2 | Code segment privilege level |
| summary_o | output | 18 | Registered mode and size summary |

## Verification
The bench builds the block with the package defaults: a 2-bit privilege field and 2-bit size codes, which give an 18-bit summary. With these widths the six mode inputs span only 64 combinations, so a sweep can reach every one of them. Each combination is strobed with a rotating privilege value and paging bit, which exercises every submode branch and every size selection against an independent reference model. Directed phases cover holding the word without a strobe and a reset that overrides a strobe in the same cycle.

// File: rtl/cmd_pkg.sv
// Package: shared field widths, encodings and the summary word layout
// for the processor mode and size decoder. The first member is the MSB.
package cmd_pkg;
    parameter int DPL_W = 2;   // privilege level width
    parameter int SZ_W  = 2;   // log2-bytes size code width
    parameter int SUB_W = 3;   // submode code width

    typedef enum logic { MODE_LEGACY = 1'b0, MODE_LONG = 1'b1 } mode_e;

    typedef enum logic [SUB_W-1:0] {
        SUB_REAL   = 3'd0,
        SUB_V86    = 3'd1,
        SUB_PROT   = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    localparam logic [SZ_W-1:0] SZ_16 = 2'd1;
    localparam logic [SZ_W-1:0] SZ_32 = 2'd2;
    localparam logic [SZ_W-1:0] SZ_64 = 2'd3;

    typedef struct packed {
        logic [SZ_W-1:0]  stack;
        logic [SZ_W-1:0]  alt_addr;
        logic [SZ_W-1:0]  def_addr;
        logic [SZ_W-1:0]  alt_op;
        logic [SZ_W-1:0]  def_op;
        logic             prot;
        logic             paging;
        logic [DPL_W-1:0] cpl;
        submode_e         submode;
        mode_e            mode;
    } summary_t;
endpackage

// File: rtl/cmd_mode_classify.sv
// Module: cmd_mode_classify
// Purpose: sort the control bits into a mode and a submode.
// Assumes: the inputs are already stable, architecturally legal values.
module cmd_mode_classify
    import cmd_pkg::*;
(
    input  logic     long_act,
    input  logic     prot_en,
    input  logic     v86,
    input  logic     cs_long,
    output mode_e    mode,
    output submode_e submode
);
    // Long mode splits on the code segment long bit; legacy mode splits on protection and the v86 flag.
    always_comb begin
        if (long_act) begin
            mode    = MODE_LONG;
            submode = cs_long ? SUB_64 : SUB_COMPAT;
        end else begin
            mode = MODE_LEGACY;
            if (!prot_en)  submode = SUB_REAL;
            else if (v86)  submode = SUB_V86;
            else           submode = SUB_PROT;
        end
    end
endmodule

// File: rtl/cmd_size_select.sv
// Module: cmd_size_select
// Purpose: choose the operand, address and stack size codes.
// Assumes: is64 is asserted exactly when the submode is 64-bit.
module cmd_size_select
    import cmd_pkg::*;
(
    input  logic            is64,
    input  logic            cs_dsize,
    input  logic            ss_dsize,
    output logic [SZ_W-1:0] def_op,
    output logic [SZ_W-1:0] alt_op,
    output logic [SZ_W-1:0] def_addr,
    output logic [SZ_W-1:0] alt_addr,
    output logic [SZ_W-1:0] stack
);
    // Operand pair: 64-bit code still defaults to 32-bit operands.
    always_comb begin
        if (is64 || cs_dsize) begin
            def_op = SZ_32;
            alt_op = SZ_16;
        end else begin
            def_op = SZ_16;
            alt_op = SZ_32;
        end
    end

    // Address pair: 64-bit submode overrides the code segment size bit.
    always_comb begin
        if (is64) begin
            def_addr = SZ_64;
            alt_addr = SZ_32;
        end else if (cs_dsize) begin
            def_addr = SZ_32;
            alt_addr = SZ_16;
        end else begin
            def_addr = SZ_16;
            alt_addr = SZ_32;
        end
    end

    // Stack width: 64-bit submode, else the stack segment size bit.
    always_comb begin
        if (is64)          stack = SZ_64;
        else if (ss_dsize) stack = SZ_32;
        else               stack = SZ_16;
    end

    // An override prefix must always select a width other than the default.
    always_comb begin
        assert_op_pair_differs_R3: assert (def_op != alt_op);
        assert_addr_pair_differs_R4: assert (def_addr != alt_addr);
    end
endmodule

// File: rtl/cpu_mode_decoder.sv
// Module: cpu_mode_decoder (top)
// Purpose: register a summary of mode, privilege and size codes, loaded on
// each recompute strobe and held between strobes.
// Assumes: synchronous active-low reset; the inputs are stable while recalc_i is high.
module cpu_mode_decoder
    import cmd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        recalc_i,
    input  logic                        long_act_i,
    input  logic                        prot_en_i,
    input  logic                        paging_i,
    input  logic                        v86_i,
    input  logic                        cs_long_i,
    input  logic                        cs_dsize_i,
    input  logic                        ss_dsize_i,
    input  logic [DPL_W-1:0]            cs_dpl_i,
    output logic [$bits(summary_t)-1:0] summary_o
);
    localparam int SUM_W = $bits(summary_t);

    localparam summary_t RESET_SUM = '{
        stack:    SZ_16,
        alt_addr: SZ_32,
        def_addr: SZ_16,
        alt_op:   SZ_32,
        def_op:   SZ_16,
        prot:     1'b0,
        paging:   1'b0,
        cpl:      '0,
        submode:  SUB_REAL,
        mode:     MODE_LEGACY
    };

    mode_e            nx_mode;
    submode_e         nx_sub;
    logic [SZ_W-1:0]  nx_dop, nx_aop, nx_dad, nx_aad, nx_stk;
    summary_t         nx_sum, sum_q;

    cmd_mode_classify u_classify (
        .long_act (long_act_i),
        .prot_en  (prot_en_i),
        .v86      (v86_i),
        .cs_long  (cs_long_i),
        .mode     (nx_mode),
        .submode  (nx_sub)
    );

    cmd_size_select u_sizes (
        .is64     (nx_sub == SUB_64),
        .cs_dsize (cs_dsize_i),
        .ss_dsize (ss_dsize_i),
        .def_op   (nx_dop),
        .alt_op   (nx_aop),
        .def_addr (nx_dad),
        .alt_addr (nx_aad),
        .stack    (nx_stk)
    );

    // Assemble the candidate summary from both sub-blocks and the copied bits.
    always_comb begin
        nx_sum = '{
            stack:    nx_stk,
            alt_addr: nx_aad,
            def_addr: nx_dad,
            alt_op:   nx_aop,
            def_op:   nx_dop,
            prot:     prot_en_i,
            paging:   paging_i,
            cpl:      cs_dpl_i,
            submode:  nx_sub,
            mode:     nx_mode
        };
    end

    // Summary register: reset wins, then the strobe loads the candidate.
    always_ff @(posedge clk) begin
        if (!rst_n)        sum_q <= RESET_SUM;
        else if (recalc_i) sum_q <= nx_sum;
    end

    assign summary_o = SUM_W'(sum_q);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !recalc_i |=> $stable(summary_o));
    assert_long_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (recalc_i && long_act_i) |=> (sum_q.mode == MODE_LONG));
    assert_real_submode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (recalc_i && !long_act_i && !prot_en_i) |=> (sum_q.submode == SUB_REAL));
    assert_wide_stack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (recalc_i && long_act_i && cs_long_i) |=> (sum_q.stack == SZ_64 && sum_q.def_addr == SZ_64));
    assert_cpl_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_i |=> (sum_q.cpl == $past(cs_dpl_i) && sum_q.paging == $past(paging_i)));
endmodule

// File: tb/cpu_mode_decoder_bench.sv
// Bench: directed vector table, exhaustive sweep against a reference model,
// hold and reset cases.
module cpu_mode_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recalc_i = 1'b0;
    logic        long_act_i = 1'b0, prot_en_i = 1'b0, paging_i = 1'b0, v86_i = 1'b0;
    logic        cs_long_i = 1'b0, cs_dsize_i = 1'b0, ss_dsize_i = 1'b0;
    logic [1:0]  cs_dpl_i = 2'd0;
    logic [17:0] summary_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cpu_mode_decoder u_cpu_mode_decoder (
        .clk(clk), .rst_n(rst_n), .recalc_i(recalc_i),
        .long_act_i(long_act_i), .prot_en_i(prot_en_i), .paging_i(paging_i),
        .v86_i(v86_i), .cs_long_i(cs_long_i), .cs_dsize_i(cs_dsize_i),
        .ss_dsize_i(ss_dsize_i), .cs_dpl_i(cs_dpl_i), .summary_o(summary_o)
    );

    // Reset summary per R8, laid out per R9.
    localparam logic [17:0] RESET_WORD =
        {2'd1, 2'd2, 2'd1, 2'd2, 2'd1, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0};

    // Directed table: {lma,pe,vm,cs_long,cs_dsize,ss_dsize}, expected submode.
    typedef struct packed { logic [5:0] in6; logic [2:0] sub; } vec_t;
    localparam vec_t VECS [8] = '{
        '{6'b000000, 3'd0}, '{6'b011000, 3'd1}, '{6'b010000, 3'd2},
        '{6'b110000, 3'd3}, '{6'b100100, 3'd4}, '{6'b001100, 3'd0},
        '{6'b111111, 3'd4}, '{6'b101011, 3'd3}
    };

    // Reference model from R1..R6, packed per R9.
    function automatic logic [17:0] ref_word(logic [5:0] in6, logic [1:0] dpl, logic pg);
        logic lma, pe, vm, csl, csd, ssd, is64;
        logic [2:0] sub;
        logic [1:0] dop, aop, dad, aad, stk;
        {lma, pe, vm, csl, csd, ssd} = in6;
        if (lma) sub = csl ? 3'd4 : 3'd3;
        else if (!pe) sub = 3'd0;
        else sub = vm ? 3'd1 : 3'd2;
        is64 = (sub == 3'd4);
        if (is64 || csd) begin dop = 2'd2; aop = 2'd1; end
        else begin dop = 2'd1; aop = 2'd2; end
        if (is64) begin dad = 2'd3; aad = 2'd2; end
        else if (csd) begin dad = 2'd2; aad = 2'd1; end
        else begin dad = 2'd1; aad = 2'd2; end
        stk = is64 ? 2'd3 : (ssd ? 2'd2 : 2'd1);
        return {stk, aad, dad, aop, dop, pe, pg, dpl, sub, lma};
    endfunction

    task automatic check(string req, logic [17:0] act, logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] in6, logic [1:0] dpl, logic pg);
        {long_act_i, prot_en_i, v86_i, cs_long_i, cs_dsize_i, ss_dsize_i} = in6;
        cs_dpl_i = dpl;
        paging_i = pg;
    endtask

    // Drive at negedge with strobe, drop strobe at next negedge; the word is then loaded.
    task automatic strobe(logic [5:0] in6, logic [1:0] dpl, logic pg);
        @(negedge clk);
        drive(in6, dpl, pg);
        recalc_i = 1'b1;
        @(negedge clk);
        recalc_i = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] held;
        repeat (3) @(negedge clk);
        check("R8 reset value", summary_o, RESET_WORD);
        rst_n = 1'b1;

        // Directed table: the submode field at [3:1] (R1, R2, R9), then the full word.
        for (int i = 0; i < 8; i++) begin
            strobe(VECS[i].in6, 2'(i), i[0]);
            check("R1/R2 submode field", {15'd0, summary_o[3:1]}, {15'd0, VECS[i].sub});
            check("R3..R6 full word", summary_o, ref_word(VECS[i].in6, 2'(i), i[0]));
        end

        // Exhaustive sweep of the six mode inputs (R1..R6, R9).
        for (int c = 0; c < 64; c++) begin
            strobe(6'(c), 2'(c >> 1), c[2]);
            check("R1-R6 sweep", summary_o, ref_word(6'(c), 2'(c >> 1), c[2]));
        end

        // R7: inputs change without a strobe; the word must hold.
        strobe(6'b100100, 2'd3, 1'b1);
        held = summary_o;
        @(negedge clk);
        drive(6'b010010, 2'd1, 1'b0);
        repeat (3) @(negedge clk);
        check("R7 hold without strobe", summary_o, held);
        recalc_i = 1'b1;
        @(negedge clk);
        recalc_i = 1'b0;
        check("R7 load on strobe", summary_o, ref_word(6'b010010, 2'd1, 1'b0));

        // R8: reset held in the same cycle as a strobe; reset wins.
        @(negedge clk);
        drive(6'b111111, 2'd2, 1'b1);
        rst_n = 1'b0;
        recalc_i = 1'b1;
        @(negedge clk);
        recalc_i = 1'b0;
        check("R8 reset beats strobe", summary_o, RESET_WORD);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 holds after reset", summary_o, RESET_WORD);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule